// File: doc/BRIEF.md
# Cascadable CRC Register Slice

This block is one 16-bit piece of a serial CRC generator and checker. Identical slices chain to make CRC registers of 16, 32 or 56 bits. Each slice shifts toward its most significant end once per enabled clock. It keeps only its own share of the generator polynomial's taps. A shared feedback bit, formed in the topmost slice from the incoming data bit and the register MSB, is broadcast to the `rfb` input of every slice. Each slice passes its MSB to the slice above through `ro` → `sei`.

A 4-bit code on `sel` picks the slice's role from a 16-entry lookup. The entry gives a 16-bit tap mask, a set-or-clear choice for each 4-bit group on preset, the source of the LSB (the feedback bit or the serial expansion input), and whether the check word is inverted as it leaves. Code 0 turns the slice into a plain shift register with no taps, so a lower-order polynomial can run in a chain built for a higher-order one.

To generate a CRC, hold `cwg` high while data bits enter on `din`. Then drop `cwg` and clock out the check bits on `dcw`. To check a frame, feed data and check bits with `cwg` high and read `nonzero` from the slices.

Top module: `crc_slice`

## Requirements
- R1: While `rst_n` is low the register is all zeros, so `q` = 0 and `nonzero` = 0; assertion is asynchronous and release takes effect through a two-stage synchronizer.
- R2: A clock edge with `preset_n` low loads the preset pattern, with priority over shifting. Codes 1 to 7 load 16'hFFFF. Code 8 loads 16'hFF00. Code 0 and codes 9 to 15 load 16'h0000. Bit g of the group mask covers bits 4g+3..4g.
- R3: A clock edge with `preset_n` high and `shift_en` low leaves `q` unchanged.
- R4: A clock edge with `preset_n` and `shift_en` high loads bit i (i ≥ 1) with q[i-1] XOR (tap[i] AND `rfb`). The tap masks are: code 1 16'h8005, code 2 16'h1021, code 3 16'h04C1, code 4 16'h1DB7, code 5 16'h8222, code 6 16'hF080, code 7 16'h4BDA, code 8 16'h2300.
- R5: On a shift, bit 0 takes `rfb` for codes 1, 2 and 4. For all other codes it takes `sei` XOR (tap[0] AND `rfb`).
- R6: Code 0 and codes 9 to 15 have no taps: each shift moves `q` up one place and loads `sei` into bit 0, whatever `rfb` is.
- R7: `ro` is q[15], and `fb_out` = `cwg` AND (`din` XOR q[15]).
- R8: `dcw` equals `din` while `cwg` is high. While `cwg` is low it equals q[15], inverted for codes 3 and 4 only.
- R9: `nonzero` is high exactly when any bit of `q` is set.
- R10: With codes 3 and 4 on the top two slices, the chain follows a 32-bit LFSR with generator 32'h04C11DB7. After a frame with its inverted check word appended, the top 32 bits hold 32'hC704DD7B.
- R11: With code 1 on the top slice and codes 0 or 9-15 below, appending the uninverted check word leaves the slice all zero. A frame with one data bit flipped leaves it nonzero.
- R12: With codes 5, 6, 7 and 8 from top to bottom, the 64-bit chain follows the generator 64'h8222F0804BDA2300. The low byte stays zero, and a frame with its check word appended leaves every slice at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low clear, synchronously released |
| sel | input | 4 | Role code of this slice |
| preset_n | input | 1 | Active-low preset, sampled on the clock edge |
| shift_en | input | 1 | Clock enable for shifting |
| cwg | input | 1 | High: data phase with feedback; low: check word shift-out |
| din | input | 1 | Serial data bit |
| sei | input | 1 | Serial expansion input from the slice below |
| rfb | input | 1 | Broadcast feedback bit |
| q | output | 16 | Register contents |
| ro | output | 1 | Register MSB, toward the slice above |
| fb_out | output | 1 | Feedback term formed by this slice |
| dcw | output | 1 | Serial data or check word bit |
| nonzero | output | 1 | High when any register bit is set |

## Verification
A single 16-bit slice with idle neighbours on the off code and on an unused code shows that the neighbours stay inert. Its good and corrupted frames separate a zero remainder from a detected error. A two-slice 32-bit run with an inverted check word exercises the expansion path into a slice whose LSB takes the serial input, and it lands on the fixed non-zero residue. A four-slice 56-bit run checks the split preset and the zero low byte. A preloaded ones pattern pushed through slices on disabled codes shows pure shifting while the feedback bit toggles. A mid-run reset and a stalled shift cycle cover the hold and clear paths.

// File: rtl/crc_slice_pkg.sv
package crc_slice_pkg;

  localparam int SLICE_W = 16;
  localparam int GRP_W   = 4;
  localparam int N_GRP   = SLICE_W / GRP_W;
  localparam int SEL_W   = 4;

  typedef struct packed {
    logic [SLICE_W-1:0] taps;
    logic [N_GRP-1:0]   grp_set;
    logic               lsb_from_fb;
    logic               invert_cw;
  } slice_cfg_t;

  // Role table: tap share, preset groups, LSB source, check word polarity.
  function automatic slice_cfg_t cfg_lookup(input logic [SEL_W-1:0] code);
    slice_cfg_t c;
    c = '0;
    case (code)
      4'd1: c = '{taps: 16'h8005, grp_set: 4'b1111, lsb_from_fb: 1'b1, invert_cw: 1'b0};
      4'd2: c = '{taps: 16'h1021, grp_set: 4'b1111, lsb_from_fb: 1'b1, invert_cw: 1'b0};
      4'd3: c = '{taps: 16'h04C1, grp_set: 4'b1111, lsb_from_fb: 1'b0, invert_cw: 1'b1};
      4'd4: c = '{taps: 16'h1DB7, grp_set: 4'b1111, lsb_from_fb: 1'b1, invert_cw: 1'b1};
      4'd5: c = '{taps: 16'h8222, grp_set: 4'b1111, lsb_from_fb: 1'b0, invert_cw: 1'b0};
      4'd6: c = '{taps: 16'hF080, grp_set: 4'b1111, lsb_from_fb: 1'b0, invert_cw: 1'b0};
      4'd7: c = '{taps: 16'h4BDA, grp_set: 4'b1111, lsb_from_fb: 1'b0, invert_cw: 1'b0};
      4'd8: c = '{taps: 16'h2300, grp_set: 4'b1100, lsb_from_fb: 1'b0, invert_cw: 1'b0};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/crc_slice_rst_sync.sv
module crc_slice_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/crc_slice_cfg_rom.sv
module crc_slice_cfg_rom
  import crc_slice_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  output logic [SLICE_W-1:0] taps,
  output logic [SLICE_W-1:0] preset_val,
  output logic               lsb_from_fb,
  output logic               invert_cw
);

  slice_cfg_t cfg;

  always_comb begin
    cfg = cfg_lookup(sel);
  end

  assign taps        = cfg.taps;
  assign lsb_from_fb = cfg.lsb_from_fb;
  assign invert_cw   = cfg.invert_cw;

  // Expand each group's set/clear choice across its bits.
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign preset_val[g*GRP_W +: GRP_W] = {GRP_W{cfg.grp_set[g]}};
  end

endmodule

// File: rtl/crc_slice_shreg.sv
module crc_slice_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         preset_n,
  input  logic         shift_en,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] preset_val,
  input  logic         lsb_from_fb,
  input  logic         sei,
  input  logic         rfb,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  // Galois step: each bit takes its lower neighbour, XORed with the
  // broadcast feedback wherever this slice holds a tap.
  assign q_nxt[0] = lsb_from_fb ? rfb : (sei ^ (taps[0] & rfb));
  for (genvar i = 1; i < W; i++) begin : g_bit
    assign q_nxt[i] = q_r[i-1] ^ (taps[i] & rfb);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      q_r <= '0;
    end else if (!preset_n) begin
      q_r <= preset_val;
    end else if (shift_en) begin
      q_r <= q_nxt;
    end
  end

  assign q = q_r;

  // R3: a stalled cycle keeps the register contents
  a_r3_hold_when_stalled: assert property (@(posedge clk) disable iff (!arst_n)
    (preset_n && !shift_en) |=> $stable(q_r));

  // R2: preset overrides any pending shift
  a_r2_preset_wins: assert property (@(posedge clk) disable iff (!arst_n)
    (!preset_n) |=> (q_r == $past(preset_val)));

endmodule

// File: rtl/crc_slice.sv
module crc_slice
  import crc_slice_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               preset_n,
  input  logic               shift_en,
  input  logic               cwg,
  input  logic               din,
  input  logic               sei,
  input  logic               rfb,
  output logic [SLICE_W-1:0] q,
  output logic               ro,
  output logic               fb_out,
  output logic               dcw,
  output logic               nonzero
);

  logic               arst_n;
  logic [SLICE_W-1:0] taps_w;
  logic [SLICE_W-1:0] preset_w;
  logic               lsb_fb_w;
  logic               inv_w;
  logic [SLICE_W-1:0] q_w;

  crc_slice_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (arst_n)
  );

  crc_slice_cfg_rom u_rom (
    .sel         (sel),
    .taps        (taps_w),
    .preset_val  (preset_w),
    .lsb_from_fb (lsb_fb_w),
    .invert_cw   (inv_w)
  );

  crc_slice_shreg #(.W(SLICE_W)) u_reg (
    .clk         (clk),
    .arst_n      (arst_n),
    .preset_n    (preset_n),
    .shift_en    (shift_en),
    .taps        (taps_w),
    .preset_val  (preset_w),
    .lsb_from_fb (lsb_fb_w),
    .sei         (sei),
    .rfb         (rfb),
    .q           (q_w)
  );

  assign q       = q_w;
  assign ro      = q_w[SLICE_W-1];
  assign fb_out  = cwg & (din ^ q_w[SLICE_W-1]);
  assign dcw     = cwg ? din : (q_w[SLICE_W-1] ^ inv_w);
  assign nonzero = |q_w;

  // R6: the off code behaves as a plain shift register fed from below
  a_r6_off_code_shifts: assert property (@(posedge clk) disable iff (!arst_n)
    (sel == '0 && preset_n && shift_en) |=>
      (q == {$past(q[SLICE_W-2:0]), $past(sei)}));

  // R2: the off code clears on preset
  a_r2_off_code_clears: assert property (@(posedge clk) disable iff (!arst_n)
    (sel == '0 && !preset_n) |=> (q == '0 && !nonzero));

  // R2: the lowest 56th-order slice keeps its low byte clear on preset
  a_r2_low_byte_clear: assert property (@(posedge clk) disable iff (!arst_n)
    (sel == 4'd8 && !preset_n) |=> (q == 16'hFF00));

  // R5: a slice holding the constant term loads the feedback bit into bit 0
  a_r5_lsb_from_feedback: assert property (@(posedge clk) disable iff (!arst_n)
    (sel == 4'd1 && preset_n && shift_en) |=> (q[0] == $past(rfb)));

endmodule

// File: tb/crc_slice_test.sv
module crc_slice_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, preset_n, shift_en, cwg, din;
  logic [3:0] sel3, sel2, sel1, sel0;
  logic [15:0] q3, q2, q1, q0;
  logic ro3, ro2, ro1, ro0;
  logic fb3, fb2, fb1, fb0;
  logic dcw3, dcw2, dcw1, dcw0;
  logic nz3, nz2, nz1, nz0;

  crc_slice uut (.clk(clk), .rst_n(rst_n), .sel(sel3), .preset_n(preset_n), .shift_en(shift_en),
    .cwg(cwg), .din(din), .sei(ro2), .rfb(fb3), .q(q3), .ro(ro3), .fb_out(fb3), .dcw(dcw3), .nonzero(nz3));
  crc_slice sl2 (.clk(clk), .rst_n(rst_n), .sel(sel2), .preset_n(preset_n), .shift_en(shift_en),
    .cwg(cwg), .din(din), .sei(ro1), .rfb(fb3), .q(q2), .ro(ro2), .fb_out(fb2), .dcw(dcw2), .nonzero(nz2));
  crc_slice sl1 (.clk(clk), .rst_n(rst_n), .sel(sel1), .preset_n(preset_n), .shift_en(shift_en),
    .cwg(cwg), .din(din), .sei(ro0), .rfb(fb3), .q(q1), .ro(ro1), .fb_out(fb1), .dcw(dcw1), .nonzero(nz1));
  crc_slice sl0 (.clk(clk), .rst_n(rst_n), .sel(sel0), .preset_n(preset_n), .shift_en(shift_en),
    .cwg(cwg), .din(din), .sei(1'b0), .rfb(fb3), .q(q0), .ro(ro0), .fb_out(fb0), .dcw(dcw0), .nonzero(nz0));

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [63:0] exp_q;
  logic [63:0] gen_m;
  logic        inv_m;
  logic        cwb [64];

  logic [63:0] sbv [$];
  string       sbt [$];

  task automatic chk64(input logic [63:0] a, input logic [63:0] e, input string t);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", t, a, e);
    end
  endtask

  task automatic chk1(input logic a, input logic e, input string t);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", t, a, e);
    end
  endtask

  // Monitor: compare the chain against the queued model state after each edge
  always @(posedge clk) begin
    logic [63:0] v;
    string t;
    #2;
    if (sbv.size() > 0) begin
      v = sbv.pop_front();
      t = sbt.pop_front();
      chk64({q3, q2, q1, q0}, v, t);
      chk1(nz3, |v[63:48], "R9 nonzero top slice");
      chk1(nz0, |v[15:0],  "R9 nonzero bottom slice");
    end
  end

  task automatic push(input string t);
    sbv.push_back(exp_q);
    sbt.push_back(t);
  endtask

  task automatic set_mode(input logic [3:0] s3, input logic [3:0] s2, input logic [3:0] s1,
                          input logic [3:0] s0, input logic [63:0] g, input logic inv);
    sel3 = s3; sel2 = s2; sel1 = s1; sel0 = s0;
    gen_m = g; inv_m = inv;
  endtask

  task automatic do_preset(input logic [63:0] pv);
    preset_n = 1'b0; shift_en = 1'b1; cwg = 1'b0; din = 1'b0;
    #1;
    exp_q = pv;
    push("R2 preset pattern");
    @(posedge clk); @(negedge clk);
    preset_n = 1'b1;
  endtask

  task automatic step(input logic d, input logic c, input logic en, input string t, output logic seen);
    logic fb;
    logic ed;
    din = d; cwg = c; shift_en = en; preset_n = 1'b1;
    #1;
    fb = c & (d ^ exp_q[63]);
    chk1(fb3, fb, "R7 fb_out");
    ed = c ? d : (exp_q[63] ^ inv_m);
    chk1(dcw3, ed, "R8 dcw");
    seen = dcw3;
    if (en) exp_q = (exp_q << 1) ^ (fb ? gen_m : 64'h0);
    push(t);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic gen_frame(input int nd, input logic [63:0] msg, input int ord,
                           input logic [63:0] pv, input string t);
    logic s;
    do_preset(pv);
    for (int i = nd - 1; i >= 0; i--) begin
      step(msg[i], 1'b1, 1'b1, t, s);
      if (i == nd / 2) step(1'b1, 1'b1, 1'b0, "R3 stalled shift", s);
    end
    for (int k = 0; k < ord; k++) begin
      step(1'b0, 1'b0, 1'b1, t, s);
      cwb[k] = s;
    end
  endtask

  task automatic chk_frame(input int nd, input logic [63:0] msg, input int ord,
                           input logic [63:0] pv, input int flip, input string t);
    logic s;
    do_preset(pv);
    for (int i = nd - 1; i >= 0; i--) step(msg[i] ^ (i == flip), 1'b1, 1'b1, t, s);
    for (int k = 0; k < ord; k++) step(cwb[k], 1'b1, 1'b1, t, s);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic s;
    rst_n = 1'b0; preset_n = 1'b1; shift_en = 1'b0; cwg = 1'b0; din = 1'b0;
    set_mode(4'd0, 4'd0, 4'd0, 4'd0, 64'h0, 1'b0);
    exp_q = '0;
    repeat (3) @(negedge clk);
    chk64({q3, q2, q1, q0}, 64'h0, "R1 register clear in reset");
    chk1(nz3, 1'b0, "R1 nonzero low in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk64({q3, q2, q1, q0}, 64'h0, "R1 clear after release");

    // 16-bit polynomial in the top slice; neighbours on off and unused codes
    set_mode(4'd1, 4'd0, 4'd12, 4'd0, 64'h8005_0000_0000_0000, 1'b0);
    gen_frame(24, 64'h00A5_C319, 16, 64'hFFFF_0000_0000_0000, "R4 R5 16-bit state");
    chk_frame(24, 64'h00A5_C319, 16, 64'hFFFF_0000_0000_0000, -1, "R11 16-bit check");
    chk1(nz3, 1'b0, "R11 clean frame leaves zero");
    chk64({q3, q2, q1, q0}, 64'h0, "R11 clean frame register");
    chk_frame(24, 64'h00A5_C319, 16, 64'hFFFF_0000_0000_0000, 7, "R11 16-bit corrupt");
    chk1(nz3, 1'b1, "R11 corrupted frame flagged");

    // 32-bit polynomial over two slices, inverted check word
    set_mode(4'd3, 4'd4, 4'd0, 4'd13, 64'h04C1_1DB7_0000_0000, 1'b1);
    gen_frame(32, 64'h1234_ABCD, 32, 64'hFFFF_FFFF_0000_0000, "R10 32-bit state");
    chk_frame(32, 64'h1234_ABCD, 32, 64'hFFFF_FFFF_0000_0000, -1, "R10 32-bit check");
    chk64({32'h0, q3, q2}, {32'h0, 32'hC704_DD7B}, "R10 fixed residue");

    // 56-bit polynomial over four slices
    set_mode(4'd5, 4'd6, 4'd7, 4'd8, 64'h8222_F080_4BDA_2300, 1'b0);
    gen_frame(40, 64'h00C3_5A96_0F1E, 56, 64'hFFFF_FFFF_FFFF_FF00, "R12 56-bit state");
    chk64({56'h0, q0[7:0]}, 64'h0, "R12 low byte zero");
    chk_frame(40, 64'h00C3_5A96_0F1E, 56, 64'hFFFF_FFFF_FFFF_FF00, -1, "R12 56-bit check");
    chk1(nz3 | nz2 | nz1 | nz0, 1'b0, "R12 clean frame leaves zero");

    // Pure shifting through disabled and unused codes
    set_mode(4'd0, 4'd1, 4'd2, 4'd0, 64'h0, 1'b0);
    do_preset(64'h0000_FFFF_FFFF_0000);
    set_mode(4'd0, 4'd0, 4'd14, 4'd9, 64'h0, 1'b0);
    for (int i = 0; i < 40; i++) step(i[0] ^ i[2], 1'b1, 1'b1, "R6 plain shift", s);

    // Reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk64({q3, q2, q1, q0}, 64'h0, "R1 asynchronous clear");
    chk1(nz2, 1'b0, "R1 nonzero cleared");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule